// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This unit applies one of seven shift or rotate operations to a byte or word operand and returns the result, the final carry and an overflow flag. The operations are logical left shift, logical right shift, arithmetic right shift, plain rotate left and right, and rotate left and right through carry. In the through-carry rotates the incoming carry acts as one extra bit in the loop.

The count is either the fixed value 1 or an 8-bit value supplied with the request. The unit moves the operand one bit position per clock, so an operation takes as many cycles as its count. A one-cycle start pulse loads the operand, the operation and the flags. A one-cycle done pulse marks the cycle in which the outputs carry the finished result. The outputs then hold that result until the next accepted start.

Top module: `shift_rotate_unit`

## Requirements
- R1: After reset, result, carryOut, overflow, done and busy are all 0.
- R2: opSel 0 and opSel 7 both perform a logical left shift. Each step moves the operand MSB into the carry and inserts 0 at bit 0.
- R3: opSel 1 performs a logical right shift. Each step moves bit 0 into the carry and inserts 0 at the MSB.
- R4: opSel 2 performs an arithmetic right shift. Each step moves bit 0 into the carry and keeps the old MSB value in the MSB.
- R5: opSel 3 rotates left, copying the old MSB into both bit 0 and the carry. opSel 4 rotates right, copying the old bit 0 into both the MSB and the carry.
- R6: opSel 5 rotates left through carry: the old carry enters bit 0 and the old MSB becomes the carry. opSel 6 rotates right through carry: the old carry enters the MSB and the old bit 0 becomes the carry.
- R7: With countSel=0 the count is 1; with countSel=1 it is countVal (0 to 255). If start is sampled at clock edge E0 and the count N is at least 1, the unit performs one step at each of edges E1..EN. busy is 1 after E0 through EN-1. done is 1 for the single cycle after EN, so a word logical shift by 16 or more yields 0.
- R8: With isWord=0 the operation acts on bits 7:0, with bit 7 as the MSB, and result bits 15:8 equal dataIn bits 15:8. With isWord=1 it acts on all 16 bits, with bit 15 as the MSB.
- R9: A count of 0 gives result=dataIn, carryOut=carryIn and overflow=ovIn, with done high in the cycle right after E0 and busy never raised.
- R10: With a count of 1, overflow is (result MSB XOR carryOut) for opSel 0, 3, 5 and 7, and (result MSB XOR the bit below it) for opSel 1, 2, 4 and 6. With any count above 1, overflow equals ovIn.
- R11: A start asserted while busy is 1 is ignored, and the running operation finishes with its original operands.
- R12: Between done and the next accepted start, result, carryOut and overflow hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when not busy |
| isWord | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand in bits 7:0 |
| opSel | input | 3 | Operation code (see R2 to R6) |
| countSel | input | 1 | 0 = count of 1, 1 = count from countVal |
| countVal | input | 8 | Count value when countSel is 1 |
| dataIn | input | 16 | Operand |
| carryIn | input | 1 | Incoming carry flag |
| ovIn | input | 1 | Incoming overflow flag |
| result | output | 16 | Shifted or rotated operand |
| carryOut | output | 1 | Carry after the operation |
| overflow | output | 1 | Overflow after the operation |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The start of a new operation can fall in the same cycle as the done pulse of the previous one. The bench provokes this by issuing back-to-back requests, raising start in the very cycle that done is high. It then judges both results and the new operation's timing against the reference model. A second overlap is a start raised during a running operation, carrying different operands. That case is judged by checking that the result reported at done still matches the original request.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_SAL = 3'd7
  } shiftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operand and flags
    logic step;    // advance one bit position
    logic single;  // the loaded count equals one
  } ctlStrobes_t;

endpackage

// File: rtl/sru_ctrl.sv
module sru_ctrl
  import sru_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             countSel,
  input  logic [CNT_W-1:0] countVal,
  output ctlStrobes_t      strobes,
  output logic             busy,
  output logic             done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;

  ctlState_e        stateReg;
  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] effCount;
  logic             doneReg;
  logic             accept;

  assign effCount = countSel ? countVal : CNT_W'(1);
  assign accept   = (stateReg == ST_IDLE) && start;

  always_comb begin
    strobes.load   = accept;
    strobes.step   = (stateReg == ST_RUN);
    strobes.single = (effCount == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= ST_IDLE;
      cntReg   <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (stateReg)
        ST_IDLE: begin
          if (start) begin
            cntReg <= effCount;
            if (effCount == '0) doneReg <= 1'b1;
            else                stateReg <= ST_RUN;
          end
        end
        ST_RUN: begin
          cntReg <= cntReg - CNT_W'(1);
          if (cntReg == CNT_W'(1)) begin
            doneReg  <= 1'b1;
            stateReg <= ST_IDLE;
          end
        end
        default: stateReg <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateReg == ST_RUN);
  assign done = doneReg;

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R7
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateReg == ST_RUN) |=> (cntReg == $past(cntReg) - CNT_W'(1)));

  // R9
  zero_count_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && effCount == '0) |=> (done && !busy));

  // R11
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && cntReg > CNT_W'(1)) |=> busy);

endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
  import sru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              isWord,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              carryIn,
  input  logic              ovIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;
  localparam int HMSB   = HALF_W - 1;

  shiftOp_e          opReg;
  logic              wordReg;
  logic              singleReg;
  logic [DATA_W-1:0] dataReg;
  logic              carryReg;
  logic              ovReg;

  logic              goesLeft;
  logic              insBit;
  logic              curMsb;
  logic              nextCarry;
  logic [DATA_W-1:0] wideNext;
  logic [HALF_W-1:0] halfNext;
  logic [DATA_W-1:0] nextData;
  logic              newTop;
  logic              newSub;
  logic              nextOv;

  always_comb begin
    curMsb = wordReg ? dataReg[MSB] : dataReg[HMSB];
    case (opReg)
      OP_SHL, OP_SAL: begin goesLeft = 1'b1; insBit = 1'b0;       end
      OP_ROL:         begin goesLeft = 1'b1; insBit = curMsb;     end
      OP_RCL:         begin goesLeft = 1'b1; insBit = carryReg;   end
      OP_SHR:         begin goesLeft = 1'b0; insBit = 1'b0;       end
      OP_SAR:         begin goesLeft = 1'b0; insBit = curMsb;     end
      OP_ROR:         begin goesLeft = 1'b0; insBit = dataReg[0]; end
      default:        begin goesLeft = 1'b0; insBit = carryReg;   end
    endcase
    if (goesLeft) begin
      wideNext  = {dataReg[MSB-1:0], insBit};
      halfNext  = {dataReg[HMSB-1:0], insBit};
      nextCarry = curMsb;
    end else begin
      wideNext  = {insBit, dataReg[MSB:1]};
      halfNext  = {insBit, dataReg[HMSB:1]};
      nextCarry = dataReg[0];
    end
    nextData = wordReg ? wideNext : {dataReg[MSB:HALF_W], halfNext};
    newTop   = wordReg ? wideNext[MSB]   : halfNext[HMSB];
    newSub   = wordReg ? wideNext[MSB-1] : halfNext[HMSB-1];
    nextOv   = goesLeft ? (newTop ^ nextCarry) : (newTop ^ newSub);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg     <= OP_SHL;
      wordReg   <= 1'b0;
      singleReg <= 1'b0;
      dataReg   <= '0;
      carryReg  <= 1'b0;
      ovReg     <= 1'b0;
    end else if (strobes.load) begin
      opReg     <= shiftOp_e'(opSel);
      wordReg   <= isWord;
      singleReg <= strobes.single;
      dataReg   <= dataIn;
      carryReg  <= carryIn;
      ovReg     <= ovIn;
    end else if (strobes.step) begin
      dataReg  <= nextData;
      carryReg <= nextCarry;
      if (singleReg) ovReg <= nextOv;
    end
  end

  assign result   = dataReg;
  assign carryOut = carryReg;
  assign overflow = ovReg;

  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> ($stable(dataReg) && $stable(carryReg) && $stable(ovReg)));

  // R8
  byte_upper_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !wordReg) |=> (dataReg[MSB:HALF_W] == $past(dataReg[MSB:HALF_W])));

  // R10
  ov_multi_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !singleReg) |=> (ovReg == $past(ovReg)));

  // R2
  shl_zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && (opReg == OP_SHL || opReg == OP_SAL)) |=> !dataReg[0]);

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWord,
  input  logic [2:0]        opSel,
  input  logic              countSel,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              carryIn,
  input  logic              ovIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow,
  output logic              done,
  output logic              busy
);

  ctlStrobes_t strobes;

  sru_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .countSel (countSel),
    .countVal (countVal),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  sru_datapath #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .isWord   (isWord),
    .opSel    (opSel),
    .dataIn   (dataIn),
    .carryIn  (carryIn),
    .ovIn     (ovIn),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );

endmodule

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isWord = 1'b0;
  logic [2:0]  opSel = '0;
  logic        countSel = 1'b0;
  logic [7:0]  countVal = '0;
  logic [15:0] dataIn = '0;
  logic        carryIn = 1'b0;
  logic        ovIn = 1'b0;
  logic [15:0] result;
  logic        carryOut;
  logic        overflow;
  logic        done;
  logic        busy;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  shift_rotate_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .isWord(isWord), .opSel(opSel),
    .countSel(countSel), .countVal(countVal), .dataIn(dataIn),
    .carryIn(carryIn), .ovIn(ovIn), .result(result), .carryOut(carryOut),
    .overflow(overflow), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference of the requirements
  function automatic void refCalc(input bit wd, input int op, input int n,
                                  input int data, input bit cin, input bit oin,
                                  output int res, output bit co, output bit ov);
    int w = wd ? 16 : 8;
    int mask = (1 << w) - 1;
    int v = data & mask;
    bit c = cin;
    bit hi, lo;
    for (int i = 0; i < n; i++) begin
      hi = v[w-1];
      lo = v[0];
      case (op)
        0, 7: begin c = hi; v = (v << 1) & mask; end
        1:    begin c = lo; v = v >> 1; end
        2:    begin c = lo; v = (v >> 1) | (int'(hi) << (w-1)); end
        3:    begin c = hi; v = ((v << 1) & mask) | int'(hi); end
        4:    begin c = lo; v = (v >> 1) | (int'(lo) << (w-1)); end
        5:    begin v = ((v << 1) & mask) | int'(c); c = hi; end
        default: begin v = (v >> 1) | (int'(c) << (w-1)); c = lo; end
      endcase
    end
    res = wd ? v : ((data & 16'hFF00) | v);
    co = c;
    if (n == 1) begin
      if (op == 0 || op == 3 || op == 5 || op == 7) ov = v[w-1] ^ c;
      else ov = v[w-1] ^ v[w-2];
    end else ov = oin;
  endfunction

  // called at a negedge; returns at the negedge where done is expected
  task automatic runOp(input string req, input bit wd, input int op,
                       input bit sel, input int cnt, input int data,
                       input bit cin, input bit oin, input bit inject);
    int eff = sel ? cnt : 1;
    int expRes;
    bit expCo, expOv;
    bit tOk = 1'b1;
    refCalc(wd, op, eff, data, cin, oin, expRes, expCo, expOv);
    isWord = wd; opSel = 3'(op); countSel = sel; countVal = 8'(cnt);
    dataIn = 16'(data); carryIn = cin; ovIn = oin; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= eff; k++) begin
      if (k > 0) @(negedge clk);
      if (done !== (k == eff) || busy !== (k < eff)) tOk = 1'b0;
      if (inject && k == 1) begin
        start = 1'b1; dataIn = ~dataIn; opSel = 3'd3; carryIn = ~carryIn;
        countVal = 8'd1; ovIn = ~ovIn;
      end
      if (inject && k == 2) start = 1'b0;
    end
    check(tOk, req, "done/busy timing", {busy, done}, 1);
    check(result === 16'(expRes), req, "result", result, expRes);
    check(carryOut === expCo && overflow === expOv, req, "carry/overflow",
          {carryOut, overflow}, {expCo, expOv});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R7 watchdog expired act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] heldRes;
    logic heldCo, heldOv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(result === 16'h0 && carryOut === 1'b0 && overflow === 1'b0 &&
          done === 1'b0 && busy === 1'b0, "R1", "reset outputs",
          {result, carryOut, overflow, done, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runOp("R2 R10", 1, 0, 0, 0, 16'h8001, 0, 0, 0);   // SHL word by 1
    runOp("R2 R8", 0, 7, 0, 0, 16'hABC3, 0, 0, 0);    // SAL byte
    runOp("R3 R7", 1, 1, 1, 3, 16'hF00D, 1, 0, 0);    // SHR word by 3
    runOp("R4", 1, 2, 1, 2, 16'h8004, 0, 1, 0);       // SAR word by 2, ov kept
    runOp("R4 R10", 0, 2, 0, 0, 16'h1281, 0, 1, 0);   // SAR byte by 1
    runOp("R5 R8", 0, 3, 1, 3, 16'h55A1, 0, 0, 0);    // ROL byte by 3
    runOp("R5 R10", 1, 4, 0, 0, 16'h4001, 0, 0, 0);   // ROR word by 1
    runOp("R6", 1, 5, 1, 17, 16'h9C35, 1, 0, 0);      // RCL full loop
    runOp("R6 R8", 0, 6, 1, 9, 16'h7E4B, 0, 0, 0);    // RCR byte full loop
    runOp("R6 R10", 1, 5, 0, 0, 16'h4000, 1, 0, 0);   // RCL word by 1
    runOp("R6 R10", 0, 6, 0, 0, 16'h0002, 1, 0, 0);   // RCR byte by 1
    runOp("R7", 1, 0, 1, 20, 16'hFFFF, 1, 1, 0);      // SHL word by 20
    runOp("R7 R3", 1, 1, 1, 255, 16'hBEEF, 0, 0, 0);  // SHR by 255
    runOp("R9", 1, 3, 1, 0, 16'h1234, 1, 1, 0);       // count zero
    runOp("R11", 1, 6, 1, 6, 16'hC0DE, 1, 0, 1);      // start while busy
    // back-to-back: next start raised while done is high
    runOp("R7 R2", 1, 0, 1, 4, 16'h0F0F, 0, 0, 0);
    runOp("R7 R5", 0, 4, 1, 2, 16'h3306, 1, 0, 0);
    runOp("R9 R7", 0, 1, 1, 0, 16'h00F1, 0, 1, 0);
    runOp("R9 R7", 1, 2, 1, 0, 16'h8000, 1, 0, 0);
    // R12 hold after done
    heldRes = result; heldCo = carryOut; heldOv = overflow;
    repeat (4) @(negedge clk);
    check(result === heldRes && carryOut === heldCo && overflow === heldOv &&
          done === 1'b0, "R12", "outputs held", result, heldRes);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule